// File: doc/BRIEF.md
# Header-Tagged Packet Byte Queue

This block is a synchronous first-in, first-out queue for packet bytes. Each stored entry holds one data byte and one marker bit. The marker bit is set when the byte is written while the header-load indicator is high, and cleared for every other byte. A downstream reader can therefore find packet boundaries without parsing the stream again. By default the queue holds sixteen entries.

A producer writes a byte with a write strobe, and the byte is accepted only when room remains. A consumer pulls a byte with a read strobe, and a byte is delivered only when the queue holds one. The byte and its marker appear on registered outputs one clock after the read is taken, and they keep their value until the next read that is taken.

Two clears exist. The global reset is synchronous and active low. The soft clear is synchronous and active high, and a neighbouring timeout can use it to drop stale contents. Both clears return the queue to empty and zero the outputs.

Top module: `hdr_fifo`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are full=0, empty=1, rd_data=0 and rd_hdr=0.
- R2: A rising edge with soft_clr=1 empties the queue and zeroes rd_data and rd_hdr, the same as the global reset. A write or read requested in that same cycle is discarded, and the next byte written is the next byte read.
- R3: A write requested while full=1 is ignored. The count stays at the depth, and the ignored byte never appears at the output.
- R4: A read requested while empty=1 is ignored. empty stays 1, and rd_data and rd_hdr keep their value.
- R5: Bytes leave in the order they were written. This holds across pointer wraparound after more than 16 writes.
- R6: Each entry stores the value of wr_hdr at its write, and that value appears on rd_hdr together with the byte (1 = header byte, 0 = other byte).
- R7: full=1 exactly when 16 entries are stored, and empty=1 exactly when none is stored. The two are never 1 together.
- R8: A read and a write in the same cycle while the queue is neither empty nor full perform both operations and leave the count unchanged.
- R9: rd_data and rd_hdr change only on a rising edge where a read is taken or a clear is applied. Otherwise they hold.
- R10: A read and a write together while empty=1 perform only the write. When full=1, they perform only the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_clr | input | 1 | Synchronous flush, active high |
| wr_en | input | 1 | Write request |
| wr_hdr | input | 1 | Marks the byte being written as a header |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Last byte read, registered |
| rd_hdr | output | 1 | Marker bit of the last byte read |
| full | output | 1 | Queue holds 16 entries |
| empty | output | 1 | Queue holds no entry |

## Verification
A vector table steps through a short mixed stream of writes, reads, simultaneous operations and reads of an empty queue. It tells correct ordering and marker alignment apart from off-by-one pointer faults, and from reads that wrongly proceed when the queue is empty. Directed runs then fill the queue to the limit and push one extra byte. They drain it across the wraparound point, which separates a correct full or empty threshold from one that is off by one entry. Separate runs flush the queue with a write pending in the same cycle, and assert the global reset while the queue holds data, which shows that both clears drop the stored bytes and zero the outputs.

// File: rtl/hdr_fifo_pkg.sv
package hdr_fifo_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PUSH = 2'b01,
      OP_POP  = 2'b10,
      OP_BOTH = 2'b11
   } fifo_op_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/hdr_fifo_ptr.sv
module hdr_fifo_ptr #(
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   import hdr_fifo_pkg::*;

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_inc;

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_natural
         always_comb ptr_inc = ptr_q + PTR_W'(1);
      end else begin : g_wrap_compare
         always_comb ptr_inc = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear) ptr_q <= '0;
      else if (adv)        ptr_q <= ptr_inc;
   end

   assign ptr = ptr_q;

   // R5: a pointer never addresses past the last entry
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr_q) < DEPTH);

   // R5: an advance moves the pointer, an idle cycle keeps it
   p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clear) |=> $stable(ptr_q));

endmodule

// File: rtl/hdr_fifo_occ.sv
module hdr_fifo_occ #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic             pop,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   import hdr_fifo_pkg::*;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             full_q, empty_q;
   fifo_op_e         op;

   assign op = fifo_op_e'({pop, push});

   always_comb begin
      unique case (op)
         OP_PUSH: cnt_d = cnt_q + CNT_W'(1);
         OP_POP:  cnt_d = cnt_q - CNT_W'(1);
         default: cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q   <= '0;
         full_q  <= 1'b0;
         empty_q <= 1'b1;
      end else begin
         cnt_q   <= cnt_d;
         full_q  <= (cnt_d == CNT_W'(DEPTH));
         empty_q <= (cnt_d == '0);
      end
   end

   assign count = cnt_q;
   assign full  = full_q;
   assign empty = empty_q;

   // R3: occupancy never exceeds the depth
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_q) <= DEPTH);

   // R7: flags agree with the stored count and never both set
   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_q && empty_q));
   p_flag_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full_q == (32'(cnt_q) == DEPTH));

   // R8: simultaneous push and pop keep the count
   p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !clear) |=> $stable(cnt_q));

   // R2: clear empties the queue
   p_clear_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (empty_q && !full_q && cnt_q == '0));

endmodule

// File: rtl/hdr_fifo_store.sv
module hdr_fifo_store #(
   parameter int DEPTH          = 16,
   parameter int WIDTH          = 9,
   parameter bit CLEAR_ON_RESET = 1'b0,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PTR_W-1:0] waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [PTR_W-1:0] raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_cleared
         for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            always_ff @(posedge clk) begin
               if (!rst_n)                        cells[i] <= '0;
               else if (we && waddr == PTR_W'(i)) cells[i] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) cells[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = cells[raddr];

endmodule

// File: rtl/hdr_fifo.sv
module hdr_fifo #(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              wr_en,
   input  logic              wr_hdr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_hdr,
   output logic              full,
   output logic              empty
);
   localparam int ENTRY_W = DATA_W + 1;
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W   = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hdr_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("hdr_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic               full_w, empty_w;
   logic               push, pop;
   logic [PTR_W-1:0]   wptr, rptr;
   logic [CNT_W-1:0]   count;
   logic [ENTRY_W-1:0] head;
   logic [DATA_W-1:0]  dout_q;
   logic               tag_q;

   assign push = wr_en && !full_w  && !soft_clr;
   assign pop  = rd_en && !empty_w && !soft_clr;

   hdr_fifo_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk(clk), .rst_n(rst_n), .clear(soft_clr), .adv(push), .ptr(wptr));

   hdr_fifo_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk(clk), .rst_n(rst_n), .clear(soft_clr), .adv(pop), .ptr(rptr));

   hdr_fifo_occ #(.DEPTH(DEPTH)) u_occ (
      .clk(clk), .rst_n(rst_n), .clear(soft_clr), .push(push), .pop(pop),
      .count(count), .full(full_w), .empty(empty_w));

   hdr_fifo_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk(clk), .rst_n(rst_n), .we(push), .waddr(wptr),
      .wdata({wr_hdr, wr_data}), .raddr(rptr), .rdata(head));

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) begin
         dout_q <= '0;
         tag_q  <= 1'b0;
      end else if (pop) begin
         dout_q <= head[DATA_W-1:0];
         tag_q  <= head[DATA_W];
      end
   end

   assign rd_data = dout_q;
   assign rd_hdr  = tag_q;
   assign full    = full_w;
   assign empty   = empty_w;

   // R3: a write into a full queue leaves it full and the count unchanged
   p_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_w && wr_en && !rd_en && !soft_clr) |=> (full_w && $stable(count)));

   // R4: a read of an empty queue leaves it empty and the output held
   p_empty_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_w && rd_en && !wr_en && !soft_clr) |=> (empty_w && $stable(rd_data)));

   // R9: outputs hold when no read is taken and no clear is applied
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rd_en && !empty_w) && !soft_clr) |=> ($stable(rd_data) && $stable(rd_hdr)));

   // R2: soft clear zeroes the outputs
   p_soft_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (rd_data == '0 && !rd_hdr && empty_w));

   // R10: read and write together on an empty queue only store
   p_empty_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_w && rd_en && wr_en && !soft_clr) |=> (!empty_w && $stable(rd_data)));

endmodule

// File: tb/hdr_fifo_test.sv
module hdr_fifo_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_clr = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_hdr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_hdr;
   logic       full;
   logic       empty;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hdr_fifo uut (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
      .wr_hdr(wr_hdr), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .rd_hdr(rd_hdr), .full(full), .empty(empty));

   // row: wr, hdr, data[8], rd, exp_data[8], exp_hdr, exp_full, exp_empty
   localparam int NVEC = 12;
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
      {1'b1, 1'b0, 8'hB2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
      {1'b1, 1'b0, 8'hC3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hA1, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b0, 8'hD4, 1'b1, 8'hB2, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hD4, 1'b0, 1'b0, 1'b1},
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hD4, 1'b0, 1'b0, 1'b1},
      {1'b1, 1'b1, 8'hE5, 1'b1, 8'hD4, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b0, 8'hD4, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hE5, 1'b1, 1'b0, 1'b1},
      {1'b0, 1'b0, 8'h00, 1'b0, 8'hE5, 1'b1, 1'b0, 1'b1}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive at the falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic w, input logic h, input logic [7:0] d,
                       input logic r, input logic s);
      wr_en = w; wr_hdr = h; wr_data = d; rd_en = r; soft_clr = s;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; soft_clr = 1'b0; wr_hdr = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      // R1 reset state while rst_n is low
      check("R1", "full",  full,    0);
      check("R1", "empty", empty,   1);
      check("R1", "data",  rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 R6 R8 R4 R9 R10: vector walk
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][21], VEC[i][20], VEC[i][19:12], VEC[i][11], 1'b0);
         check("R5", $sformatf("vec%0d data", i), rd_data, VEC[i][10:3]);
         check("R6", $sformatf("vec%0d hdr",  i), rd_hdr,  VEC[i][2]);
         check("R7", $sformatf("vec%0d full", i), full,    VEC[i][1]);
         check("R4", $sformatf("vec%0d empty", i), empty,  VEC[i][0]);
      end

      // R7 fill to the limit, pointers start mid-array so this wraps (R5)
      for (int i = 0; i < 16; i++) begin
         step(1'b1, (i % 4) == 0, 8'(8'h40 + i), 1'b0, 1'b0);
         check("R7", $sformatf("fill%0d full", i), full, (i == 15) ? 1 : 0);
      end
      check("R7", "filled empty", empty, 0);
      // R3 extra write ignored
      step(1'b1, 1'b1, 8'hEE, 1'b0, 1'b0);
      check("R3", "still full", full, 1);
      check("R3", "data held", rd_data, 8'hE5);
      // R10 read and write together when full: only the read happens
      step(1'b1, 1'b0, 8'hEF, 1'b1, 1'b0);
      check("R10", "read taken", rd_data, 8'h40);
      check("R10", "write dropped", full, 0);
      for (int i = 1; i < 16; i++) begin
         step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
         check("R5", $sformatf("drain%0d data", i), rd_data, 8'(8'h40 + i));
         check("R6", $sformatf("drain%0d hdr", i), rd_hdr, (i % 4) == 0);
      end
      check("R3", "drained empty", empty, 1);
      step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      check("R3", "extra byte absent", rd_data, 8'h4F);

      // R2 soft clear with a pending write in the same cycle
      step(1'b1, 1'b1, 8'h11, 1'b0, 1'b0);
      step(1'b1, 1'b0, 8'h22, 1'b0, 1'b0);
      step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      check("R2", "pre-clear data", rd_data, 8'h11);
      step(1'b1, 1'b0, 8'h33, 1'b0, 1'b1);
      check("R2", "clear empty", empty, 1);
      check("R2", "clear data", rd_data, 0);
      check("R2", "clear hdr", rd_hdr, 0);
      step(1'b1, 1'b1, 8'h5A, 1'b0, 1'b0);
      step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      check("R2", "next read", rd_data, 8'h5A);
      check("R2", "next hdr", rd_hdr, 1);
      check("R2", "empty after", empty, 1);

      // R1 global reset while holding data
      step(1'b1, 1'b0, 8'h66, 1'b0, 1'b0);
      step(1'b1, 1'b0, 8'h77, 1'b0, 1'b0);
      rst_n = 1'b0;
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      check("R1", "mid reset empty", empty, 1);
      check("R1", "mid reset data", rd_data, 0);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      check("R1", "post reset read ignored", rd_data, 0);
      check("R1", "post reset empty", empty, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule